// File: doc/BRIEF.md
# Serial Channel Command and Status Core

This block is the register core of one channel in a multi-channel serial controller. A processor reaches it through a small byte-wide register port. A mode slot gives access to two mode bytes that sit behind a self-advancing pointer. A status slot reports receive, transmit and error conditions. A command slot takes a byte that carries both enable/disable bits and an encoded action. A data slot pops received bytes on a read and sends a byte on a write.

On the line side, a deserializer offers received bytes over a valid/ready handshake into a three-entry receive queue. A break detector pulses a break input, which the core turns into a zero byte plus a break status bit. The core emits a one-cycle strobe with a byte for the serializer. It also raises three per-channel request flags (receive ready, transmit ready, break seen) that the controller's interrupt logic combines across channels.

Top module: `uart_chan_regcore`

## Requirements
- R1: After a synchronous reset the status byte reads 0x00, receive and transmit are disabled (`rx_ready` low, no transmit strobe), the mode pointer selects the first mode byte, the queue is empty and all three request flags are low.
- R2: In a command byte (slot 2), bit 0 turns receive on, bit 1 turns it off, bit 2 turns transmit on and bit 3 turns it off. When the on and off bits of the same direction are set together, the off bit wins.
- R3: Each read or write of slot 0 uses the mode byte picked by the pointer, and the pointer then moves to the second byte and stays there. Only command code 1 (upper nibble) moves it back to the first byte.
- R4: Turning transmit on sets status bits 2 (transmit ready) and 3 (transmit empty) and raises `irq_txrdy`. Turning it off, or command code 3 (which acts after the enable bits), clears both bits and drops `irq_txrdy`.
- R5: Command code 2 disables receive, empties the queue, clears status bit 0 and drops `irq_rxrdy`. It overrides a receive-on bit in the same byte.
- R6: Command code 4 clears status bits 4 to 7. Command code 5 drops `irq_brk`. Codes 6 to 15 change nothing.
- R7: The queue holds 3 bytes. `rx_ready` is high only while receive is on, the queue has room and no break pulse is present. Status bit 1 is set while the queue holds 3 bytes.
- R8: A byte entering an empty queue sets status bit 0 and raises `irq_rxrdy`.
- R9: A read of slot 3 returns the oldest byte and then removes it, in arrival order. Removing the last byte clears status bit 0 and drops `irq_rxrdy`.
- R10: A read of slot 3 while the queue is empty returns the last head byte and changes no state.
- R11: A `brk_evt` pulse sets status bit 7 if it is clear and puts a 0x00 byte in the queue if there is room. Removing a byte while bit 7 is set clears bit 7 and raises `irq_brk`.
- R12: A write to slot 3 gives a one-cycle `tx_strobe` with that byte on `tx_data` in the cycle after the write, but only while transmit ready is set. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe (wins over `reg_rd`) |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 2 | Slot: 0 mode, 1 status, 2 command, 3 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed slot, combinational |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue accepts the offered byte this cycle |
| brk_evt | input | 1 | One-cycle break detection pulse |
| tx_strobe | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq_rxrdy | output | 1 | Receive-ready request flag |
| irq_txrdy | output | 1 | Transmit-ready request flag |
| irq_brk | output | 1 | Break request flag |

## Verification
The bench targets the orderings inside a command byte. On/off together must leave the direction off, and a transmit-on bit combined with a transmitter reset must end cleared; a design that applied the fields in the wrong order would leave transmit enabled. It reads the queue past empty and then refills it. A design that advanced the head on the last pop, or wrote new bytes to the wrong slot, would return a stale or shuffled byte. The bench also checks that the break request appears only when the zero byte is removed, not when the break arrives. It checks that an error reset between the two clears the bit so that no request follows, and that a mode pointer which wrapped instead of saturating would be caught by repeated reads.

// File: rtl/chan_pkg.sv
package chan_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SLOT_MODE = 2'd0,
        SLOT_STAT = 2'd1,
        SLOT_CMD  = 2'd2,
        SLOT_DATA = 2'd3
    } slot_e;

    // upper nibble action codes of the command byte
    localparam logic [3:0] ACT_NONE    = 4'd0;
    localparam logic [3:0] ACT_PTR_RST = 4'd1;
    localparam logic [3:0] ACT_RX_RST  = 4'd2;
    localparam logic [3:0] ACT_TX_RST  = 4'd3;
    localparam logic [3:0] ACT_ERR_RST = 4'd4;
    localparam logic [3:0] ACT_BRK_CLR = 4'd5;

    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_clr;
    } cmd_dec_t;

    // status byte, bit 7 first
    typedef struct packed {
        logic brk;
        logic frame_err;
        logic par_err;
        logic ovr;
        logic tx_emt;
        logic tx_rdy;
        logic full;
        logic rx_rdy;
    } chan_status_t;

    function automatic cmd_dec_t decode_cmd(input logic en, input logic [7:0] b);
        cmd_dec_t d;
        d = '0;
        if (en) begin
            d.rx_on  = b[0];
            d.rx_off = b[1];
            d.tx_on  = b[2];
            d.tx_off = b[3];
            case (b[7:4])
                ACT_PTR_RST: d.ptr_rst = 1'b1;
                ACT_RX_RST:  d.rx_rst  = 1'b1;
                ACT_TX_RST:  d.tx_rst  = 1'b1;
                ACT_ERR_RST: d.err_rst = 1'b1;
                ACT_BRK_CLR: d.brk_clr = 1'b1;
                default:     ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
    import chan_pkg::*;
(
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output cmd_dec_t   dec
);
    always_comb dec = decode_cmd(cmd_wr, cmd_byte);
endmodule

// File: rtl/chan_mode_regs.sv
module chan_mode_regs #(
    parameter int W    = 8,
    parameter int NREG = 2,
    localparam int PW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          access,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          ptr_rst,
    output logic [W-1:0]  rdata,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(NREG - 1);

    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_mr
        logic [W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (access && wr && ptr == PW'(g))
                val_q <= wdata;
        end
        assign regs[g] = val_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ptr_rst)
            ptr <= '0;
        else if (access && ptr != LAST)
            ptr <= ptr + PW'(1);
    end

    assign rdata = regs[ptr];
endmodule

// File: rtl/chan_rx_fifo.sv
module chan_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  slots [DEPTH];
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] wr_idx;
    logic          do_push;
    logic          do_pop;

    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] a, input int b);
        int s;
        s = int'(a) + b;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign wr_idx  = wrap_add(rd_idx, int'(count));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (do_push && wr_idx == IW'(g))
                byte_q <= push_data;
        end
        assign slots[g] = byte_q;
    end

    assign head = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            rd_idx <= '0;
        end else if (flush) begin
            count  <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: ;
            endcase
            // the head stays on the last byte when it leaves alone
            if (do_pop && (count > CW'(1) || do_push))
                rd_idx <= wrap_add(rd_idx, 1);
        end
    end
endmodule

// File: rtl/chan_tx_ctl.sv
module chan_tx_ctl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_on,
    input  logic         tx_off,
    input  logic         thr_wr,
    input  logic [W-1:0] thr_data,
    output logic         tx_rdy,
    output logic         tx_strobe,
    output logic [W-1:0] tx_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_rdy    <= 1'b0;
            tx_strobe <= 1'b0;
            tx_data   <= '0;
        end else begin
            if (tx_off)
                tx_rdy <= 1'b0;
            else if (tx_on)
                tx_rdy <= 1'b1;
            tx_strobe <= thr_wr && tx_rdy;
            if (thr_wr && tx_rdy)
                tx_data <= thr_data;
        end
    end
endmodule

// File: rtl/uart_chan_regcore.sv
module uart_chan_regcore
    import chan_pkg::*;
#(
    parameter int FIFO_DEPTH = 3,
    parameter int MODE_REGS  = 2,
    localparam int CW = $clog2(FIFO_DEPTH + 1),
    localparam int PW = (MODE_REGS > 1) ? $clog2(MODE_REGS) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    input  logic       brk_evt,
    output logic       tx_strobe,
    output logic [7:0] tx_data,
    output logic       irq_rxrdy,
    output logic       irq_txrdy,
    output logic       irq_brk
);
    slot_e        slot;
    cmd_dec_t     cmd;
    chan_status_t status;
    logic         rd_eff;
    logic         mode_acc;
    logic [7:0]   mode_rdata;
    logic [PW-1:0] mode_ptr;
    logic [7:0]   fifo_head;
    logic [CW-1:0] fifo_cnt;
    logic         fifo_full;
    logic         fifo_empty;
    logic         rx_en;
    logic         rx_flag;
    logic         brk_bit;
    logic         brk_req;
    logic         tx_rdy;
    logic         pop;
    logic         push;
    logic         brk_push;
    logic [7:0]   push_byte;

    assign slot     = slot_e'(reg_addr);
    assign rd_eff   = reg_rd && !reg_wr;
    assign mode_acc = (reg_wr || rd_eff) && slot == SLOT_MODE;

    chan_cmd_decode u_dec (
        .cmd_wr   (reg_wr && slot == SLOT_CMD),
        .cmd_byte (reg_wdata),
        .dec      (cmd)
    );

    chan_mode_regs #(.W(BYTE_W), .NREG(MODE_REGS)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .access  (mode_acc),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .ptr_rst (cmd.ptr_rst),
        .rdata   (mode_rdata),
        .ptr     (mode_ptr)
    );

    assign rx_ready  = rx_en && !fifo_full && !brk_evt;
    assign brk_push  = brk_evt && !fifo_full;
    assign push      = brk_push || (rx_valid && rx_ready);
    assign push_byte = brk_evt ? 8'h00 : rx_data;
    assign pop       = rd_eff && slot == SLOT_DATA && !fifo_empty;

    chan_rx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (cmd.rx_rst),
        .push      (push),
        .push_data (push_byte),
        .pop       (pop),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    chan_tx_ctl #(.W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_on     (cmd.tx_on),
        .tx_off    (cmd.tx_off || cmd.tx_rst),
        .thr_wr    (reg_wr && slot == SLOT_DATA),
        .thr_data  (reg_wdata),
        .tx_rdy    (tx_rdy),
        .tx_strobe (tx_strobe),
        .tx_data   (tx_data)
    );

    // receive enable: off bit and receiver reset both beat the on bit
    always_ff @(posedge clk) begin
        if (rst)
            rx_en <= 1'b0;
        else if (cmd.rx_off || cmd.rx_rst)
            rx_en <= 1'b0;
        else if (cmd.rx_on)
            rx_en <= 1'b1;
    end

    // receive-ready flag shared by status bit 0 and the request output
    always_ff @(posedge clk) begin
        if (rst)
            rx_flag <= 1'b0;
        else if (cmd.rx_rst)
            rx_flag <= 1'b0;
        else if (push && fifo_empty)
            rx_flag <= 1'b1;
        else if (pop && fifo_cnt == CW'(1) && !push)
            rx_flag <= 1'b0;
    end

    // break status bit and break request
    always_ff @(posedge clk) begin
        if (rst) begin
            brk_bit <= 1'b0;
            brk_req <= 1'b0;
        end else begin
            if (cmd.err_rst)
                brk_bit <= 1'b0;
            else if (brk_evt && !brk_bit)
                brk_bit <= 1'b1;
            else if (pop && brk_bit)
                brk_bit <= 1'b0;

            if (cmd.brk_clr)
                brk_req <= 1'b0;
            else if (pop && brk_bit)
                brk_req <= 1'b1;
        end
    end

    always_comb begin
        status           = '0;
        status.rx_rdy    = rx_flag;
        status.full      = fifo_full;
        status.tx_rdy    = tx_rdy;
        status.tx_emt    = tx_rdy;
        status.brk       = brk_bit;
    end

    always_comb begin
        case (slot)
            SLOT_MODE: reg_rdata = mode_rdata;
            SLOT_STAT: reg_rdata = status;
            SLOT_DATA: reg_rdata = fifo_head;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign irq_rxrdy = rx_flag;
    assign irq_txrdy = tx_rdy;
    assign irq_brk   = brk_req;
endmodule

// File: rtl/chan_regcore_chk.sv
module chan_regcore_chk #(
    parameter int DEPTH = 3,
    parameter int PW    = 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          rx_ready,
    input logic          tx_strobe,
    input logic          tx_rdy,
    input logic          irq_rxrdy,
    input logic [CW-1:0] fifo_cnt,
    input logic [PW-1:0] mode_ptr
);
    assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    assert_ready_room_R7: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> fifo_cnt < CW'(DEPTH));

    assert_rxflag_count_R8: assert property (@(posedge clk) disable iff (rst)
        irq_rxrdy == (fifo_cnt != '0));

    assert_strobe_gate_R12: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |-> $past(reg_wr && reg_addr == 2'd3 && tx_rdy));

    assert_tx_off_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[3]) |=> !tx_rdy);

    assert_rx_reset_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[7:4] == 4'd2) |=> (fifo_cnt == '0 && !rx_ready));

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((reg_wr || reg_rd) && reg_addr == 2'd0) |=> mode_ptr != '0);
endmodule

bind uart_chan_regcore chan_regcore_chk #(.DEPTH(FIFO_DEPTH), .PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_ready  (rx_ready),
    .tx_strobe (tx_strobe),
    .tx_rdy    (tx_rdy),
    .irq_rxrdy (irq_rxrdy),
    .fifo_cnt  (fifo_cnt),
    .mode_ptr  (mode_ptr)
);

// File: tb/uart_chan_regcore_tb_top.sv
module uart_chan_regcore_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       brk_evt = 1'b0;
    logic       tx_strobe;
    logic [7:0] tx_data;
    logic       irq_rxrdy;
    logic       irq_txrdy;
    logic       irq_brk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic       seen_strobe;
    logic [7:0] seen_txdata;

    always #5 clk = ~clk;

    uart_chan_regcore dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .brk_evt(brk_evt), .tx_strobe(tx_strobe), .tx_data(tx_data),
        .irq_rxrdy(irq_rxrdy), .irq_txrdy(irq_txrdy), .irq_brk(irq_brk)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
        check(act === exp, req, act, exp);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        seen_strobe = tx_strobe;
        seen_txdata = tx_data;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b, output logic took);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_break();
        @(negedge clk);
        brk_evt = 1'b1;
        @(negedge clk);
        brk_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(2'd1, v);
        check_eq("R1 status", v, 8'h00);
        check_eq("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
        check_eq("R1 flags", {5'd0, irq_rxrdy, irq_txrdy, irq_brk}, 8'h00);
        check_eq("R1 strobe", {7'd0, tx_strobe}, 8'h00);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        rd_reg(2'd0, v);
        check_eq("R1 first mode byte", v, 8'h00);
        wr_reg(2'd0, 8'h3C);
        wr_reg(2'd2, 8'h10);
        wr_reg(2'd0, 8'hA5);
        wr_reg(2'd0, 8'h77);
        wr_reg(2'd2, 8'h10);
        rd_reg(2'd0, v); check_eq("R3 mode first", v, 8'hA5);
        rd_reg(2'd0, v); check_eq("R3 mode second", v, 8'h77);
        rd_reg(2'd0, v); check_eq("R3 pointer sticks", v, 8'h77);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        wr_reg(2'd3, 8'h41);
        check_eq("R12 dropped while off", {7'd0, seen_strobe}, 8'h00);
        wr_reg(2'd2, 8'h04);
        rd_reg(2'd1, v);
        check_eq("R4 tx on status", v, 8'h0C);
        check_eq("R4 tx on flag", {7'd0, irq_txrdy}, 8'h01);
        wr_reg(2'd3, 8'h5A);
        check_eq("R12 strobe", {7'd0, seen_strobe}, 8'h01);
        check_eq("R12 byte", seen_txdata, 8'h5A);
        @(negedge clk);
        check_eq("R12 one cycle", {7'd0, tx_strobe}, 8'h00);
        wr_reg(2'd2, 8'h0C);
        rd_reg(2'd1, v);
        check_eq("R2 tx off wins", v, 8'h00);
        check_eq("R4 flag off", {7'd0, irq_txrdy}, 8'h00);
        wr_reg(2'd2, 8'h04);
        wr_reg(2'd2, 8'h30);
        rd_reg(2'd1, v);
        check_eq("R4 tx reset", v, 8'h00);
        wr_reg(2'd2, 8'h34);
        rd_reg(2'd1, v);
        check_eq("R4 reset after enable", v, 8'h00);
        check_eq("R4 flag after reset", {7'd0, irq_txrdy}, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        logic took;
        push_byte(8'hEE, took);
        check_eq("R7 refused when off", {7'd0, took}, 8'h00);
        wr_reg(2'd2, 8'h03);
        push_byte(8'hEE, took);
        check_eq("R2 rx off wins", {7'd0, took}, 8'h00);
        wr_reg(2'd2, 8'h01);
        push_byte(8'h11, took);
        check_eq("R7 accepted", {7'd0, took}, 8'h01);
        rd_reg(2'd1, v);
        check_eq("R8 rx ready status", v, 8'h01);
        check_eq("R8 rx flag", {7'd0, irq_rxrdy}, 8'h01);
        push_byte(8'h22, took);
        push_byte(8'h33, took);
        rd_reg(2'd1, v);
        check_eq("R7 full status", v, 8'h03);
        push_byte(8'h44, took);
        check_eq("R7 refused when full", {7'd0, took}, 8'h00);
        rd_reg(2'd3, v); check_eq("R9 pop 1", v, 8'h11);
        rd_reg(2'd1, v); check_eq("R9 still ready", v, 8'h01);
        rd_reg(2'd3, v); check_eq("R9 pop 2", v, 8'h22);
        rd_reg(2'd3, v); check_eq("R9 pop 3", v, 8'h33);
        rd_reg(2'd1, v); check_eq("R9 drained status", v, 8'h00);
        check_eq("R9 flag dropped", {7'd0, irq_rxrdy}, 8'h00);
        rd_reg(2'd3, v); check_eq("R10 empty read", v, 8'h33);
        rd_reg(2'd1, v); check_eq("R10 no change", v, 8'h00);
        check_eq("R10 flag stays low", {7'd0, irq_rxrdy}, 8'h00);
        push_byte(8'h55, took);
        push_byte(8'h66, took);
        rd_reg(2'd3, v); check_eq("R9 refill order 1", v, 8'h55);
        rd_reg(2'd3, v); check_eq("R9 refill order 2", v, 8'h66);
    endtask

    task automatic t_rx_reset();
        logic [7:0] v;
        logic took;
        push_byte(8'hAA, took);
        push_byte(8'hBB, took);
        wr_reg(2'd2, 8'h21);
        rd_reg(2'd1, v);
        check_eq("R5 status cleared", v, 8'h00);
        check_eq("R5 flag dropped", {7'd0, irq_rxrdy}, 8'h00);
        check_eq("R5 receive off", {7'd0, rx_ready}, 8'h00);
        push_byte(8'hCC, took);
        check_eq("R5 refused after reset", {7'd0, took}, 8'h00);
    endtask

    task automatic t_break();
        logic [7:0] v;
        wr_reg(2'd2, 8'h01);
        pulse_break();
        rd_reg(2'd1, v);
        check_eq("R11 break status", v, 8'h81);
        check_eq("R11 no request yet", {7'd0, irq_brk}, 8'h00);
        rd_reg(2'd3, v);
        check_eq("R11 zero byte", v, 8'h00);
        rd_reg(2'd1, v);
        check_eq("R11 bit cleared on pop", v, 8'h00);
        check_eq("R11 request raised", {7'd0, irq_brk}, 8'h01);
        wr_reg(2'd2, 8'h50);
        @(negedge clk);
        check_eq("R6 break request cleared", {7'd0, irq_brk}, 8'h00);
        pulse_break();
        wr_reg(2'd2, 8'h40);
        rd_reg(2'd1, v);
        check_eq("R6 error reset", v, 8'h01);
        rd_reg(2'd3, v);
        @(negedge clk);
        check_eq("R6 no request after error reset", {7'd0, irq_brk}, 8'h00);
    endtask

    task automatic t_unsupported();
        logic [7:0] v;
        logic took;
        wr_reg(2'd2, 8'h04);
        push_byte(8'h99, took);
        rd_reg(2'd1, v);
        check_eq("R6 before", v, 8'h0D);
        wr_reg(2'd2, 8'h60);
        wr_reg(2'd2, 8'hA0);
        wr_reg(2'd2, 8'hF0);
        rd_reg(2'd1, v);
        check_eq("R6 codes ignored", v, 8'h0D);
        check_eq("R6 flags kept", {6'd0, irq_rxrdy, irq_txrdy}, 8'h03);
        rd_reg(2'd3, v);
        check_eq("R6 byte kept", v, 8'h99);
        rd_reg(2'd0, v);
        check_eq("R6 pointer kept", v, 8'h77);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode();
        t_tx();
        t_rx();
        t_rx_reset();
        t_break();
        t_unsupported();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule